// File: doc/BRIEF.md
# Colour Channel Auto-Cycle Selector

This block picks which colour channel a three-channel image digitiser works on. It drives two 2-bit selects. The input select steers the analog input multiplexer. The bank select picks which colour's offset and gain settings are applied. The selection comes from one of three sources: a pair of configuration bits, two external select pins, or a red, green, blue rotation that steps once per line-start pulse.

A force option fixes the input select to its own configuration field. While force is on, the bank select still follows the chosen source, so one sensor input can be digitised with each colour's offset and gain in turn. In rotation mode, external pin 0 carries the line-start pulse. Both external pins pass through a synchroniser before use. A write strobe restarts the rotation at red, and so do a hardware reset and a software reset.

Top module: `colour_cycle_sel`

## Requirements
- R1: With `mode` = 00 both selects equal `int_col` one clock after it is applied. The colour codes are red = 00, green = 01 and blue = 10.
- R2: With `mode` = 01 both selects follow `ext_pin` after it passes the input synchroniser. An `ext_pin` value of 11 gives red.
- R3: With `mode` = 10 both selects show the rotation state. Each rising edge of `ext_pin[0]` steps that state red → green → blue → red exactly once, however long the pulse lasts.
- R4: With `force_en` = 0, `in_sel` equals `bank_sel`.
- R5: With `force_en` = 1, `in_sel` equals `force_col` and `bank_sel` still follows the source chosen by `mode`.
- R6: A one-cycle pulse on `cyc_rst` returns the rotation to red, so that both selects show red in rotation mode.
- R7: A `mode` value of 11 behaves exactly like 00.
- R8: A code of 11 in `int_col` or `force_col` is taken as red. Neither select ever shows 11.
- R9: While `rst_n` is low both selects read red. After `rst_n` or `sw_rst`, the rotation starts from red.
- R10: Line-start edges that arrive while `mode` is not 10 leave the rotation state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sw_rst | input | 1 | Software reset strobe; returns the rotation to red |
| cyc_rst | input | 1 | Rotation restart strobe (a write to the restart address) |
| mode | input | 2 | Source: 00 configuration bits, 01 pins, 10 rotation, 11 as 00 |
| force_en | input | 1 | Fix the input select to `force_col` |
| int_col | input | 2 | Colour code used by the configuration-bit source |
| force_col | input | 2 | Colour code for the input select when force is on |
| ext_pin | input | 2 | External colour pins; bit 0 is also the line-start pulse |
| in_sel | output | 2 | Input multiplexer colour select (registered) |
| bank_sel | output | 2 | Offset/gain bank colour select (registered) |

## Verification
The bench mainly attacks the rotation. It uses long pulses and one-cycle pulses, checking for a design that steps on every cycle the line is high or misses a short pulse. It sends edges while another mode is active, which catches a rotor that keeps counting outside rotation mode. It restarts the rotation with both strobes, which catches a restart that leaves the state at the wrong colour. It sends the unused code 11 through every field, checking that a select never shows 11. It runs force mode with a bank source that differs from the force field, which catches input and bank selects that stay tied together. A seeded random sequence then mixes modes, fields, pin edges and restarts against a bench model of the rotation.

// File: rtl/colsel_pkg.sv
package colsel_pkg;

   localparam int COL_W = 2;

   localparam logic [COL_W-1:0] CL_RED   = 2'b00;
   localparam logic [COL_W-1:0] CL_GREEN = 2'b01;
   localparam logic [COL_W-1:0] CL_BLUE  = 2'b10;

   localparam logic [1:0] SRC_CFG  = 2'b00;
   localparam logic [1:0] SRC_PIN  = 2'b01;
   localparam logic [1:0] SRC_ROT  = 2'b10;

   // unused code 11 folds to red
   function automatic logic [COL_W-1:0] fold_code(input logic [COL_W-1:0] c);
      return (c == 2'b11) ? CL_RED : c;
   endfunction

   function automatic logic [COL_W-1:0] step_col(input logic [COL_W-1:0] c);
      case (c)
         CL_RED:   return CL_GREEN;
         CL_GREEN: return CL_BLUE;
         default:  return CL_RED;
      endcase
   endfunction

endpackage

// File: rtl/colsel_sync.sv
module colsel_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   localparam int LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_depth
      $error("colsel_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("colsel_sync: WIDTH must be at least 1");
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      logic [WIDTH-1:0] r;
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= '0;
            else        r <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= '0;
            else        r <= g_stage[i-1].r;
         end
      end
   end

   assign q = g_stage[LAST].r;

endmodule

// File: rtl/colsel_rotor.sv
module colsel_rotor
   import colsel_pkg::*;
#(
   parameter bit LINE_RISE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sw_rst,
   input  logic             restart,
   input  logic             enable,
   input  logic             line_in,
   output logic [COL_W-1:0] colour
);
   logic line_q;
   logic step;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line_q <= 1'b0;
      else        line_q <= line_in;
   end

   if (LINE_RISE) begin : g_rise
      assign step = line_in & ~line_q;
   end else begin : g_fall
      assign step = ~line_in & line_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                colour <= CL_RED;
      else if (sw_rst | restart) colour <= CL_RED;
      else if (step && enable)   colour <= step_col(colour);
   end

   // R3: an edge gives one step, never two in a row
   a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> !step);
   // R8: rotation state never holds the unused code
   a_r8_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
      colour != 2'b11);
   // R6: restart strobe lands on red
   a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> colour == CL_RED);
   // R9: software reset lands on red
   a_r9_sw_reset: assert property (@(posedge clk) disable iff (!rst_n)
      sw_rst |=> colour == CL_RED);
   // R10: no enabled edge and no clear means no change
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!(step && enable) && !restart && !sw_rst) |=> $stable(colour));

endmodule

// File: rtl/colsel_decode.sv
module colsel_decode
   import colsel_pkg::*;
(
   input  logic [1:0]       mode,
   input  logic             force_en,
   input  logic [COL_W-1:0] int_col,
   input  logic [COL_W-1:0] force_col,
   input  logic [COL_W-1:0] pin_col,
   input  logic [COL_W-1:0] rot_col,
   output logic [COL_W-1:0] in_nxt,
   output logic [COL_W-1:0] bank_nxt
);
   always_comb begin
      case (mode)
         SRC_PIN: bank_nxt = fold_code(pin_col);
         SRC_ROT: bank_nxt = rot_col;
         default: bank_nxt = fold_code(int_col);
      endcase
      in_nxt = force_en ? fold_code(force_col) : bank_nxt;
   end

   // R8: decode never produces the unused code
   always_comb begin
      a_r8_decode_legal: assert (in_nxt != 2'b11 && bank_nxt != 2'b11);
   end

endmodule

// File: rtl/colour_cycle_sel.sv
module colour_cycle_sel
   import colsel_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter bit REG_OUT     = 1'b1,
   parameter bit LINE_RISE   = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sw_rst,
   input  logic       cyc_rst,
   input  logic [1:0] mode,
   input  logic       force_en,
   input  logic [1:0] int_col,
   input  logic [1:0] force_col,
   input  logic [1:0] ext_pin,
   output logic [1:0] in_sel,
   output logic [1:0] bank_sel
);
   localparam int PIN_W = COL_W;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("colour_cycle_sel: SYNC_STAGES must be at least 2");
   end

   logic [PIN_W-1:0] pin_s;
   logic [COL_W-1:0] rot_col;
   logic [COL_W-1:0] in_nxt;
   logic [COL_W-1:0] bank_nxt;
   logic             rot_on;

   colsel_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (ext_pin),
      .q     (pin_s)
   );

   assign rot_on = (mode == SRC_ROT);

   colsel_rotor #(.LINE_RISE(LINE_RISE)) u_rotor (
      .clk     (clk),
      .rst_n   (rst_n),
      .sw_rst  (sw_rst),
      .restart (cyc_rst),
      .enable  (rot_on),
      .line_in (pin_s[0]),
      .colour  (rot_col)
   );

   colsel_decode u_dec (
      .mode      (mode),
      .force_en  (force_en),
      .int_col   (int_col),
      .force_col (force_col),
      .pin_col   (pin_s),
      .rot_col   (rot_col),
      .in_nxt    (in_nxt),
      .bank_nxt  (bank_nxt)
   );

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            in_sel   <= CL_RED;
            bank_sel <= CL_RED;
         end else begin
            in_sel   <= in_nxt;
            bank_sel <= bank_nxt;
         end
      end

      // R4: no force means one shared selection
      a_r4_shared: assert property (@(posedge clk) disable iff (!rst_n)
         !force_en |=> in_sel == bank_sel);
      // R5: force pins the input select to the force field
      a_r5_force: assert property (@(posedge clk) disable iff (!rst_n)
         force_en |=> in_sel == fold_code($past(force_col)));
      // R1 / R7: configuration source drives the bank select
      a_r1_cfg_bank: assert property (@(posedge clk) disable iff (!rst_n)
         (mode == SRC_CFG || mode == 2'b11) |=> bank_sel == fold_code($past(int_col)));
      // R8: outputs never show 11
      a_r8_out_legal: assert property (@(posedge clk) disable iff (!rst_n)
         in_sel != 2'b11 && bank_sel != 2'b11);
   end else begin : g_comb
      assign in_sel   = in_nxt;
      assign bank_sel = bank_nxt;
   end

endmodule

// File: tb/sim_colour_cycle_sel.sv
module sim_colour_cycle_sel;

   logic       clk = 1'b0;
   logic       rst_n, sw_rst, cyc_rst, force_en;
   logic [1:0] mode, int_col, force_col, ext_pin;
   logic [1:0] in_sel, bank_sel;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;
   logic [1:0] rot;

   always #2 clk = ~clk;

   colour_cycle_sel u0 (
      .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .cyc_rst(cyc_rst),
      .mode(mode), .force_en(force_en), .int_col(int_col),
      .force_col(force_col), .ext_pin(ext_pin),
      .in_sel(in_sel), .bank_sel(bank_sel)
   );

   function automatic logic [1:0] fold(input logic [1:0] c);
      return (c == 2'b11) ? 2'b00 : c;
   endfunction

   function automatic logic [1:0] nxt(input logic [1:0] c);
      return (c == 2'b00) ? 2'b01 : (c == 2'b01) ? 2'b10 : 2'b00;
   endfunction

   function automatic logic [1:0] exp_bank(input logic [1:0] m, input logic [1:0] ic,
                                           input logic [1:0] ep, input logic [1:0] r);
      case (m)
         2'b01:   return fold(ep);
         2'b10:   return r;
         default: return fold(ic);
      endcase
   endfunction

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [1:0] ein, input logic [1:0] ebank);
      checks++;
      if (in_sel !== ein || bank_sel !== ebank) begin
         errors++;
         $display("FAIL %s: in_sel=%b bank_sel=%b expected in_sel=%b bank_sel=%b",
                  tag, in_sel, bank_sel, ein, ebank);
      end
   endtask

   task automatic line_pulse(input int width);
      ext_pin[0] = 1'b1;
      wait_cyc(width);
      ext_pin[0] = 1'b0;
      wait_cyc(6);
   endtask

   task automatic strobe_cyc;
      cyc_rst = 1'b1; wait_cyc(1); cyc_rst = 1'b0; wait_cyc(3);
   endtask

   initial begin
      logic [1:0] old_ext;
      logic [1:0] eb;
      void'($urandom(32'd1234));
      rst_n = 1'b0; sw_rst = 1'b0; cyc_rst = 1'b0; force_en = 1'b0;
      mode = 2'b00; int_col = 2'b01; force_col = 2'b00; ext_pin = 2'b00;
      wait_cyc(3);
      chk("R9 reset", 2'b00, 2'b00);
      rst_n = 1'b1;
      wait_cyc(4);
      chk("R1 internal green", 2'b01, 2'b01);
      mode = 2'b11; int_col = 2'b10; wait_cyc(3);
      chk("R7 mode 11 as internal", 2'b10, 2'b10);
      int_col = 2'b11; wait_cyc(3);
      chk("R8 internal code 11", 2'b00, 2'b00);
      mode = 2'b01; ext_pin = 2'b10; wait_cyc(6);
      chk("R2 external blue", 2'b10, 2'b10);
      ext_pin = 2'b11; wait_cyc(6);
      chk("R2 external 11", 2'b00, 2'b00);
      ext_pin = 2'b10; force_en = 1'b1; force_col = 2'b01; wait_cyc(6);
      chk("R5 force green bank blue", 2'b01, 2'b10);
      force_col = 2'b11; wait_cyc(3);
      chk("R8 force code 11", 2'b00, 2'b10);
      force_en = 1'b0; wait_cyc(3);
      chk("R4 shared", 2'b10, 2'b10);
      // rotation
      ext_pin = 2'b00; wait_cyc(6);
      mode = 2'b10; strobe_cyc();
      chk("R6 restart red", 2'b00, 2'b00);
      line_pulse(7);
      chk("R3 long pulse green", 2'b01, 2'b01);
      line_pulse(1);
      chk("R3 short pulse blue", 2'b10, 2'b10);
      line_pulse(2);
      chk("R3 wrap to red", 2'b00, 2'b00);
      line_pulse(3);
      chk("R3 green again", 2'b01, 2'b01);
      force_en = 1'b1; force_col = 2'b10; wait_cyc(3);
      chk("R5 force with rotation", 2'b10, 2'b01);
      force_en = 1'b0;
      mode = 2'b00; int_col = 2'b00; wait_cyc(2);
      line_pulse(2); line_pulse(2);
      mode = 2'b10; wait_cyc(3);
      chk("R10 edges ignored outside rotation", 2'b01, 2'b01);
      strobe_cyc();
      chk("R6 restart from green", 2'b00, 2'b00);
      line_pulse(1); line_pulse(1);
      chk("R3 two pulses blue", 2'b10, 2'b10);
      sw_rst = 1'b1; wait_cyc(1); sw_rst = 1'b0; wait_cyc(3);
      chk("R9 software reset red", 2'b00, 2'b00);
      // seeded random
      rot = 2'b00;
      for (int k = 0; k < 400; k++) begin
         mode      = 2'($urandom % 4);
         force_en  = 1'($urandom % 2);
         int_col   = 2'($urandom % 4);
         force_col = 2'($urandom % 4);
         if ($urandom % 8 == 0) begin
            strobe_cyc();
            rot = 2'b00;
         end
         wait_cyc(4);
         old_ext = ext_pin;
         ext_pin = 2'($urandom % 4);
         if (mode == 2'b10 && old_ext[0] == 1'b0 && ext_pin[0] == 1'b1) rot = nxt(rot);
         wait_cyc(6);
         eb = exp_bank(mode, int_col, ext_pin, rot);
         case (mode)
            2'b01:   chk(force_en ? "R5 random pins" : "R2 random pins",
                         force_en ? fold(force_col) : eb, eb);
            2'b10:   chk(force_en ? "R5 random rotation" : "R3 random rotation",
                         force_en ? fold(force_col) : eb, eb);
            2'b11:   chk("R7 random mode 11", force_en ? fold(force_col) : eb, eb);
            default: chk(force_en ? "R5 random cfg" : "R1 random cfg",
                         force_en ? fold(force_col) : eb, eb);
         endcase
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule